// File: doc/BRIEF.md
# Hardwired Step-Sequenced Instruction Controller

This block is the control unit of a single-bus processor datapath. It keeps a small step counter, decodes the counter into one-hot timing lines and combines each timing line with decoded opcode lines and the negative flag. Every control signal is a fixed sum of products of those lines. The result is one flat vector of register gating, memory and ALU controls that drives the datapath directly.

Every instruction starts with a common three-step fetch. After that the opcode picks one tail: an add whose source operand is read from the memory address held in one register, an unconditional relative branch, or a branch taken only when the negative flag is set. Any other opcode ends the instruction at once. The counter stops while a step waits for memory and the completion input is low. The completion signal restarts the counter at the first fetch step. A run enable freezes the sequence and silences all outputs.

Top module: `hw_step_ctrl`

## Requirements
- R1: In the cycle after synchronous reset is released with run high, the control vector is the first fetch word: pc_out(0), mar_in(2), mem_rd(3), sel_four(7), alu_add(8) and z_in(9) set, all other bits clear. The bit indices in brackets hold for every requirement.
- R2: Fetch steps two and three are the same for every opcode. Step two sets z_out(10), pc_in(1), y_in(6) and wait_mfc(15). Step three sets mdr_out(4) and ir_in(5).
- R3: For opcode 2'b00 (indirect add), the steps after fetch are, in order: {r3_out(13), mar_in, mem_rd}, {r1_out(11), y_in, wait_mfc}, {mdr_out, alu_add, z_in} with sel_four clear, and {z_out, r1_in(12), done(16)}.
- R4: For opcode 2'b01 (branch), the steps after fetch are {ofs_out(14), alu_add, z_in} and then {z_out, pc_in, done}.
- R5: For opcode 2'b10 (branch if negative), n_flag is read in step four. When it is high, steps four and five match R4. When it is low, step four sets only done.
- R6: While wait_mfc is set and mfc is low, the step does not advance. The step after the waiting one is reached only after a cycle in which mfc is high.
- R7: A cycle with done set, run high, is followed by the first fetch word.
- R8: While run is low, every control bit is zero and the step does not advance, whatever mfc does.
- R9: In every cycle at most one of pc_out, mdr_out, z_out, r1_out, r3_out and ofs_out is set.
- R10: For opcode 2'b11, step four sets only done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset, returns to fetch step one |
| run | input | 1 | Sequencing enable; low freezes the step and zeroes the outputs |
| opcode | input | OPC_W (2) | Opcode field of the instruction register |
| n_flag | input | 1 | Negative condition code |
| mfc | input | 1 | Memory operation completed |
| ctrl | output | CW_W (17) | Flat control vector, bit map in R1 to R5 |

## Verification
On every cycle the assertions check that the outputs are silent when run is low, that the single internal bus has at most one driver, that a memory wait keeps the wait bit set until completion, and that done is always followed by the fetch word. The exact contents of each step for each opcode, the role of the negative flag and the reset mid-instruction can only be shown by the bench. Its vector table walks whole instructions one cycle at a time and compares every word against masks built from the requirements.

// File: rtl/hw_step_ctrl_pkg.sv
package hw_step_ctrl_pkg;

  localparam int CW_W = 17;

  // control vector bit indices
  localparam int B_PC_OUT   = 0;
  localparam int B_PC_IN    = 1;
  localparam int B_MAR_IN   = 2;
  localparam int B_MEM_RD   = 3;
  localparam int B_MDR_OUT  = 4;
  localparam int B_IR_IN    = 5;
  localparam int B_Y_IN     = 6;
  localparam int B_SEL_FOUR = 7;
  localparam int B_ALU_ADD  = 8;
  localparam int B_Z_IN     = 9;
  localparam int B_Z_OUT    = 10;
  localparam int B_R1_OUT   = 11;
  localparam int B_R1_IN    = 12;
  localparam int B_R3_OUT   = 13;
  localparam int B_OFS_OUT  = 14;
  localparam int B_WAIT_MFC = 15;
  localparam int B_DONE     = 16;

  typedef enum logic [1:0] {
    OP_ADD_IND = 2'b00,
    OP_BRANCH  = 2'b01,
    OP_BR_NEG  = 2'b10,
    OP_SPARE   = 2'b11
  } opcode_e;

endpackage

// File: rtl/step_counter.sv
module step_counter #(
  parameter int STEP_W = 3,
  localparam int LAST  = (1 << STEP_W) - 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic          restart,
  input  logic          hold,
  output logic [LAST:1] t_line
);

  logic [STEP_W-1:0] step_q;
  logic [STEP_W-1:0] step_d;

  always_comb begin
    step_d = step_q;
    if (run) begin
      if (restart)
        step_d = STEP_W'(1);
      else if (hold)
        step_d = step_q;
      else if (step_q == STEP_W'(LAST))
        step_d = STEP_W'(1);
      else
        step_d = step_q + STEP_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) step_q <= STEP_W'(1);
    else     step_q <= step_d;
  end

  // one-hot timing lines
  for (genvar k = 1; k <= LAST; k++) begin : g_tline
    assign t_line[k] = (step_q == STEP_W'(k));
  end

endmodule

// File: rtl/opcode_decoder.sv
module opcode_decoder #(
  parameter int OPC_W = 2,
  localparam int NOPC = 1 << OPC_W
) (
  input  logic [OPC_W-1:0] opcode,
  output logic [NOPC-1:0]  op_line
);

  for (genvar k = 0; k < NOPC; k++) begin : g_op
    assign op_line[k] = (opcode == OPC_W'(k));
  end

endmodule

// File: rtl/signal_encoder.sv
module signal_encoder
  import hw_step_ctrl_pkg::*;
#(
  parameter int LAST = 7,
  parameter int NOPC = 4
) (
  input  logic [LAST:1]   t,
  input  logic [NOPC-1:0] op,
  input  logic            n_flag,
  output logic [CW_W-1:0] word
);

  logic is_add, is_br, is_bn, is_spare, br_take, br_any;

  assign is_add   = op[OP_ADD_IND];
  assign is_br    = op[OP_BRANCH];
  assign is_bn    = op[OP_BR_NEG];
  assign is_spare = op[OP_SPARE];
  assign br_take  = is_br | (is_bn & n_flag);
  assign br_any   = is_br | is_bn;

  always_comb begin
    word = '0;
    word[B_PC_OUT]   = t[1];
    word[B_PC_IN]    = t[2] | (t[5] & br_any);
    word[B_MAR_IN]   = t[1] | (t[4] & is_add);
    word[B_MEM_RD]   = t[1] | (t[4] & is_add);
    word[B_MDR_OUT]  = t[3] | (t[6] & is_add);
    word[B_IR_IN]    = t[3];
    word[B_Y_IN]     = t[2] | (t[5] & is_add);
    word[B_SEL_FOUR] = t[1];
    word[B_ALU_ADD]  = t[1] | (t[6] & is_add) | (t[4] & br_take);
    word[B_Z_IN]     = t[1] | (t[6] & is_add) | (t[4] & br_take);
    word[B_Z_OUT]    = t[2] | (t[7] & is_add) | (t[5] & br_any);
    word[B_R1_OUT]   = t[5] & is_add;
    word[B_R1_IN]    = t[7] & is_add;
    word[B_R3_OUT]   = t[4] & is_add;
    word[B_OFS_OUT]  = t[4] & br_take;
    word[B_WAIT_MFC] = t[2] | (t[5] & is_add);
    word[B_DONE]     = (t[7] & is_add) | (t[5] & br_any)
                     | (t[4] & is_bn & ~n_flag) | (t[4] & is_spare);
  end

endmodule

// File: rtl/hw_step_ctrl.sv
module hw_step_ctrl
  import hw_step_ctrl_pkg::*;
#(
  parameter int STEP_W = 3,
  parameter int OPC_W  = 2,
  localparam int LAST  = (1 << STEP_W) - 1,
  localparam int NOPC  = 1 << OPC_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [OPC_W-1:0] opcode,
  input  logic             n_flag,
  input  logic             mfc,
  output logic [CW_W-1:0]  ctrl
);

  logic [LAST:1]   t_line;
  logic [NOPC-1:0] op_line;
  logic [CW_W-1:0] word;

  step_counter #(.STEP_W(STEP_W)) u_cnt (
    .clk     (clk),
    .rst     (rst),
    .run     (run),
    .restart (word[B_DONE]),
    .hold    (word[B_WAIT_MFC] & ~mfc),
    .t_line  (t_line)
  );

  opcode_decoder #(.OPC_W(OPC_W)) u_dec (
    .opcode  (opcode),
    .op_line (op_line)
  );

  signal_encoder #(.LAST(LAST), .NOPC(NOPC)) u_enc (
    .t      (t_line),
    .op     (op_line),
    .n_flag (n_flag),
    .word   (word)
  );

  assign ctrl = run ? word : '0;

endmodule

// File: rtl/hw_step_ctrl_chk.sv
module hw_step_ctrl_chk
  import hw_step_ctrl_pkg::*;
(
  input logic            clk,
  input logic            rst,
  input logic            run,
  input logic            mfc,
  input logic [CW_W-1:0] ctrl
);

  logic [CW_W-1:0] fetch_one;
  always_comb begin
    fetch_one = '0;
    fetch_one[B_PC_OUT]   = 1'b1;
    fetch_one[B_MAR_IN]   = 1'b1;
    fetch_one[B_MEM_RD]   = 1'b1;
    fetch_one[B_SEL_FOUR] = 1'b1;
    fetch_one[B_ALU_ADD]  = 1'b1;
    fetch_one[B_Z_IN]     = 1'b1;
  end

  AST_IDLE_WHEN_STOPPED: assert property (@(posedge clk) disable iff (rst)
    !run |-> ctrl == '0);  // R8

  AST_SINGLE_BUS_DRIVER: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ctrl[B_PC_OUT], ctrl[B_MDR_OUT], ctrl[B_Z_OUT],
              ctrl[B_R1_OUT], ctrl[B_R3_OUT], ctrl[B_OFS_OUT]}));  // R9

  AST_WAIT_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (run && ctrl[B_WAIT_MFC] && !mfc) |=> (!run || ctrl[B_WAIT_MFC]));  // R6

  AST_DONE_RESTARTS: assert property (@(posedge clk) disable iff (rst)
    (run && ctrl[B_DONE]) |=> (!run || ctrl == fetch_one));  // R7

  AST_DONE_NOT_WAITING: assert property (@(posedge clk) disable iff (rst)
    !(ctrl[B_DONE] && ctrl[B_WAIT_MFC]));  // R6

endmodule

bind hw_step_ctrl hw_step_ctrl_chk u_chk (
  .clk  (clk),
  .rst  (rst),
  .run  (run),
  .mfc  (mfc),
  .ctrl (ctrl)
);

// File: tb/tb_hw_step_ctrl.sv
module tb_hw_step_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int W = 17;

  // bit masks from the requirement bit map
  localparam logic [W-1:0] PCO = W'(1) << 0,  PCI = W'(1) << 1,  MARI = W'(1) << 2;
  localparam logic [W-1:0] RD  = W'(1) << 3,  MDRO = W'(1) << 4, IRI = W'(1) << 5;
  localparam logic [W-1:0] YI  = W'(1) << 6,  S4 = W'(1) << 7,   ADD = W'(1) << 8;
  localparam logic [W-1:0] ZI  = W'(1) << 9,  ZO = W'(1) << 10,  R1O = W'(1) << 11;
  localparam logic [W-1:0] R1I = W'(1) << 12, R3O = W'(1) << 13, OFS = W'(1) << 14;
  localparam logic [W-1:0] WT  = W'(1) << 15, DN = W'(1) << 16;

  localparam logic [W-1:0] F1 = PCO | MARI | RD | S4 | ADD | ZI;
  localparam logic [W-1:0] F2 = ZO | PCI | YI | WT;
  localparam logic [W-1:0] F3 = MDRO | IRI;
  localparam logic [W-1:0] A4 = R3O | MARI | RD;
  localparam logic [W-1:0] A5 = R1O | YI | WT;
  localparam logic [W-1:0] A6 = MDRO | ADD | ZI;
  localparam logic [W-1:0] A7 = ZO | R1I | DN;
  localparam logic [W-1:0] B4 = OFS | ADD | ZI;
  localparam logic [W-1:0] B5 = ZO | PCI | DN;
  localparam logic [W-1:0] E4 = DN;
  localparam logic [W-1:0] DRV = PCO | MDRO | ZO | R1O | R3O | OFS;

  typedef struct packed {
    logic         run;
    logic [1:0]   opc;
    logic         n;
    logic         mfc;
    logic [W-1:0] exp;
    logic [7:0]   req;
  } vec_t;

  localparam int NV = 42;
  localparam vec_t VECS [NV] = '{
    // indirect add, memory ready at once: R1 R2 R3
    '{1'b1, 2'd0, 1'b0, 1'b1, F1, 8'd1},
    '{1'b1, 2'd0, 1'b0, 1'b1, F2, 8'd2},
    '{1'b1, 2'd0, 1'b0, 1'b1, F3, 8'd2},
    '{1'b1, 2'd0, 1'b0, 1'b1, A4, 8'd3},
    '{1'b1, 2'd0, 1'b0, 1'b1, A5, 8'd3},
    '{1'b1, 2'd0, 1'b0, 1'b1, A6, 8'd3},
    '{1'b1, 2'd0, 1'b0, 1'b1, A7, 8'd3},
    // branch: R4, then R7
    '{1'b1, 2'd1, 1'b0, 1'b1, F1, 8'd7},
    '{1'b1, 2'd1, 1'b0, 1'b1, F2, 8'd2},
    '{1'b1, 2'd1, 1'b0, 1'b1, F3, 8'd2},
    '{1'b1, 2'd1, 1'b0, 1'b1, B4, 8'd4},
    '{1'b1, 2'd1, 1'b0, 1'b1, B5, 8'd4},
    // branch if negative, taken: R5
    '{1'b1, 2'd2, 1'b1, 1'b1, F1, 8'd7},
    '{1'b1, 2'd2, 1'b1, 1'b1, F2, 8'd2},
    '{1'b1, 2'd2, 1'b1, 1'b1, F3, 8'd2},
    '{1'b1, 2'd2, 1'b1, 1'b1, B4, 8'd5},
    '{1'b1, 2'd2, 1'b1, 1'b1, B5, 8'd5},
    // branch if negative, not taken: R5
    '{1'b1, 2'd2, 1'b0, 1'b1, F1, 8'd7},
    '{1'b1, 2'd2, 1'b0, 1'b1, F2, 8'd2},
    '{1'b1, 2'd2, 1'b0, 1'b1, F3, 8'd2},
    '{1'b1, 2'd2, 1'b0, 1'b1, E4, 8'd5},
    // spare opcode: R10
    '{1'b1, 2'd3, 1'b1, 1'b1, F1, 8'd7},
    '{1'b1, 2'd3, 1'b1, 1'b1, F2, 8'd2},
    '{1'b1, 2'd3, 1'b1, 1'b1, F3, 8'd2},
    '{1'b1, 2'd3, 1'b1, 1'b1, E4, 8'd10},
    // indirect add with slow memory and a run pause: R6 R8
    '{1'b1, 2'd0, 1'b0, 1'b0, F1, 8'd7},
    '{1'b1, 2'd0, 1'b0, 1'b0, F2, 8'd6},
    '{1'b1, 2'd0, 1'b0, 1'b0, F2, 8'd6},
    '{1'b1, 2'd0, 1'b0, 1'b1, F2, 8'd6},
    '{1'b1, 2'd0, 1'b0, 1'b0, F3, 8'd6},
    '{1'b1, 2'd0, 1'b0, 1'b0, A4, 8'd6},
    '{1'b1, 2'd0, 1'b0, 1'b0, A5, 8'd6},
    '{1'b0, 2'd0, 1'b0, 1'b1, '0, 8'd8},
    '{1'b0, 2'd0, 1'b0, 1'b1, '0, 8'd8},
    '{1'b1, 2'd0, 1'b0, 1'b0, A5, 8'd8},
    '{1'b1, 2'd0, 1'b0, 1'b1, A5, 8'd6},
    '{1'b1, 2'd0, 1'b0, 1'b1, A6, 8'd6},
    '{1'b1, 2'd0, 1'b0, 1'b1, A7, 8'd3},
    // run low at fetch step one, then resume: R8 R7
    '{1'b0, 2'd1, 1'b0, 1'b1, '0, 8'd8},
    '{1'b1, 2'd1, 1'b0, 1'b1, F1, 8'd7},
    '{1'b1, 2'd1, 1'b0, 1'b1, F2, 8'd2},
    '{1'b1, 2'd1, 1'b0, 1'b1, F3, 8'd2}
  };

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         run = 1'b0;
  logic [1:0]   opcode = 2'd0;
  logic         n_flag = 1'b0;
  logic         mfc = 1'b0;
  logic [W-1:0] ctrl;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hw_step_ctrl dut (
    .clk    (clk),
    .rst    (rst),
    .run    (run),
    .opcode (opcode),
    .n_flag (n_flag),
    .mfc    (mfc),
    .ctrl   (ctrl)
  );

  task automatic check_word(input logic [W-1:0] exp, input int req);
    checks++;
    if (ctrl !== exp) begin
      errors++;
      $display("FAIL R%0d: ctrl=%h expected=%h at %0t", req, ctrl, exp, $time);
    end
  endtask

  task automatic check_drivers();  // R9
    checks++;
    if ($countones(ctrl & DRV) > 1) begin
      errors++;
      $display("FAIL R9: drivers=%h expected at most one set", ctrl & DRV);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < NV; i++) begin
      if (i > 0) @(negedge clk);
      run    = VECS[i].run;
      opcode = VECS[i].opc;
      n_flag = VECS[i].n;
      mfc    = VECS[i].mfc;
      #1;
      check_word(VECS[i].exp, int'(VECS[i].req));
      check_drivers();
    end

    // R1: reset in the middle of an instruction returns to fetch step one
    @(negedge clk);
    run = 1'b1; opcode = 2'd0; mfc = 1'b1;
    #1 check_word(A4, 3);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    #1 check_word(F1, 1);

    // R5: n_flag is only read at step four; high elsewhere does not matter
    opcode = 2'd2; n_flag = 1'b1;
    @(negedge clk); #1 check_word(F2, 2);
    @(negedge clk); #1 check_word(F3, 2);
    n_flag = 1'b0;
    @(negedge clk); #1 check_word(E4, 5);
    @(negedge clk); #1 check_word(F1, 7);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule